// File: doc/BRIEF.md
# Line Read Prefetch Buffer

This block holds one cache line of four 64-bit Qwords between a memory-side producer and a 32-bit consumer bus. Qwords are written one at a time and Dwords are read out one at a time, so the two sides run at independent rates. A transaction begins with a start pulse that carries the requested Dword address within the line. Each transaction places its first stored Qword in buffer location 0. Reading begins at either the even or the odd Dword of that Qword.

Each Qword write carries a source select. A memory write is stored at the next free location. A cache write-back delivers the whole line in linear order, beginning at Qword 0. The buffer counts these arrivals and keeps only the Qwords from the requested Qword onward. It accepts and discards the ones that come earlier. A transaction closes when the last Dword of the line has been read or when the abort input is raised.

Top module: `lrb_line_buf`

## Requirements
- R1: While reset is asserted and right after it is released, `rd_valid_o` and `wr_ready_o` are 0.
- R2: In the cycle after a start pulse, `wr_ready_o` is 1 and `rd_valid_o` is 0. A start pulse also restarts any transaction already running.
- R3: `start_addr_i[0]` selects the starting Dword (0 = even, 1 = odd). `start_addr_i[2:1]` is the requested Qword index within the line.
- R4: Memory writes (`wr_src_i` = 0) go to consecutive locations starting at 0. The Dwords of each Qword are read out low half (bits 31:0) first, then high half (bits 63:32).
- R5: With an odd start, the first Dword read is bits 63:32 of location 0. Reading then continues in order through the line.
- R6: Write-backs (`wr_src_i` = 1) are numbered 0 to 3 in arrival order. Arrival k is stored in location k minus the requested index when k is at least the requested index. Otherwise it is accepted and dropped.
- R7: `rd_valid_o` is 1 only when the Qword holding the current Dword has been written. While `rd_ready_i` is 0, `rd_valid_o` and `rd_data_o` hold their values.
- R8: `wr_ready_o` goes to 0 once 4 minus the requested index locations have been filled. A refused write stores nothing.
- R9: After the last Dword of the line is read, the transaction ends and both `rd_valid_o` and `wr_ready_o` are 0.
- R10: In the cycle after abort is raised, both outputs are 0, and the next transaction reads nothing until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start pulse |
| start_addr_i | input | 3 | Requested address: [2:1] Qword index, [0] Dword select |
| abort_i | input | 1 | Ends the current transaction |
| wr_valid_i | input | 1 | Qword write request |
| wr_src_i | input | 1 | 0 = memory, 1 = line-order write-back |
| wr_data_i | input | 64 | Qword write data |
| wr_ready_o | output | 1 | Write is accepted in this cycle |
| rd_valid_o | output | 1 | Current Dword is available |
| rd_ready_i | input | 1 | Consumer takes the Dword |
| rd_data_o | output | 32 | Current Dword |

## Verification
The even-start and odd-start memory fills show whether the Dword selector and the low-then-high read order are correct. Write-back runs with requested indices 2 and 3 show whether arrival counting, drop decisions and location offsets are right. A memory fill with a non-zero index shows that memory data still lands at location 0 and that the line-end limit refuses the extra write. Reading ahead of the writer, followed by an abort and a fresh start, shows whether valid is gated by write progress and whether stale contents stay hidden.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    parameter int QW_W    = 64;
    parameter int DW_W    = 32;
    parameter int LINE_QW = 4;

    localparam int DPQ    = QW_W / DW_W;
    localparam int DSEL_W = $clog2(DPQ);
    localparam int QIDX_W = $clog2(LINE_QW);
    localparam int CNT_W  = QIDX_W + 1;
    localparam int RIDX_W = QIDX_W + DSEL_W;
    localparam int NDW    = LINE_QW * DPQ;

    typedef enum logic {
        SRC_MEM = 1'b0,
        SRC_WB  = 1'b1
    } src_e;

    typedef logic [LINE_QW-1:0][QW_W-1:0] line_t;

    typedef struct packed {
        logic              active;
        logic [QIDX_W-1:0] req_qw;
        logic [CNT_W-1:0]  wptr;
        logic [CNT_W-1:0]  wb_cnt;
        logic [RIDX_W-1:0] rptr;
    } ctl_t;
endpackage

// File: rtl/lrb_wr_path.sv
module lrb_wr_path
    import lrb_pkg::*;
(
    input  logic              active,
    input  logic [QIDX_W-1:0] req_qw,
    input  logic [CNT_W-1:0]  wptr,
    input  logic [CNT_W-1:0]  wb_cnt,
    input  logic              wr_valid,
    input  logic              wr_src,
    output logic              wr_ready,
    output logic              store_en,
    output logic [QIDX_W-1:0] store_loc,
    output logic              wb_adv,
    output logic [CNT_W-1:0]  limit
);
    logic             accept;
    logic [CNT_W-1:0] req_ext;
    logic [CNT_W-1:0] wb_off;

    always_comb begin
        req_ext  = {1'b0, req_qw};
        limit    = CNT_W'(LINE_QW) - req_ext;
        wr_ready = active && (wptr < limit);
        accept   = wr_valid && wr_ready;
        wb_off   = wb_cnt - req_ext;
        wb_adv   = accept && (src_e'(wr_src) == SRC_WB);
        if (src_e'(wr_src) == SRC_WB) begin
            store_en  = accept && (wb_cnt >= req_ext) && (wb_cnt < CNT_W'(LINE_QW));
            store_loc = wb_off[QIDX_W-1:0];
        end else begin
            store_en  = accept;
            store_loc = wptr[QIDX_W-1:0];
        end
    end
endmodule

// File: rtl/lrb_rd_mux.sv
module lrb_rd_mux
    import lrb_pkg::*;
(
    input  line_t             line,
    input  logic [RIDX_W-1:0] rptr,
    output logic [DW_W-1:0]   rd_data
);
    logic [NDW-1:0][DW_W-1:0] dw_view;

    for (genvar q = 0; q < LINE_QW; q++) begin : g_qw
        for (genvar d = 0; d < DPQ; d++) begin : g_dw
            assign dw_view[q*DPQ+d] = line[q][d*DW_W +: DW_W];
        end
    end

    assign rd_data = dw_view[rptr];
endmodule

// File: rtl/lrb_line_buf.sv
module lrb_line_buf
    import lrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RIDX_W-1:0] start_addr_i,
    input  logic              abort_i,
    input  logic              wr_valid_i,
    input  logic              wr_src_i,
    input  logic [QW_W-1:0]   wr_data_i,
    output logic              wr_ready_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [DW_W-1:0]   rd_data_o
);
    ctl_t  ctl_d, ctl_q;
    line_t line_d, line_q;

    logic              store_en;
    logic [QIDX_W-1:0] store_loc;
    logic              wb_adv;
    logic [CNT_W-1:0]  limit;
    logic [RIDX_W-1:0] last_idx;
    logic [CNT_W-1:0]  rd_qw;
    logic              rd_fire;

    lrb_wr_path u_wr (
        .active    (ctl_q.active),
        .req_qw    (ctl_q.req_qw),
        .wptr      (ctl_q.wptr),
        .wb_cnt    (ctl_q.wb_cnt),
        .wr_valid  (wr_valid_i),
        .wr_src    (wr_src_i),
        .wr_ready  (wr_ready_o),
        .store_en  (store_en),
        .store_loc (store_loc),
        .wb_adv    (wb_adv),
        .limit     (limit)
    );

    lrb_rd_mux u_rd (
        .line    (line_q),
        .rptr    (ctl_q.rptr),
        .rd_data (rd_data_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        line_d   = line_q;
        rd_qw    = {1'b0, ctl_q.rptr[RIDX_W-1:DSEL_W]};
        last_idx = {limit[QIDX_W-1:0] - QIDX_W'(1), {DSEL_W{1'b1}}};
        rd_valid_o = ctl_q.active && (rd_qw < ctl_q.wptr);
        rd_fire  = rd_valid_o && rd_ready_i;

        if (store_en) begin
            line_d[store_loc] = wr_data_i;
            ctl_d.wptr        = ctl_q.wptr + CNT_W'(1);
        end
        if (wb_adv) begin
            ctl_d.wb_cnt = ctl_q.wb_cnt + CNT_W'(1);
        end
        if (rd_fire) begin
            if (ctl_q.rptr == last_idx) begin
                ctl_d = '0;
            end else begin
                ctl_d.rptr = ctl_q.rptr + RIDX_W'(1);
            end
        end
        if (start_i) begin
            ctl_d.active = 1'b1;
            ctl_d.req_qw = start_addr_i[RIDX_W-1:DSEL_W];
            ctl_d.wptr   = '0;
            ctl_d.wb_cnt = '0;
            ctl_d.rptr   = {{QIDX_W{1'b0}}, start_addr_i[DSEL_W-1:0]};
        end
        if (abort_i) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            line_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            line_q <= line_d;
        end
    end
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker
    import lrb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            abort_i,
    input logic            wr_valid_i,
    input logic            wr_ready_o,
    input logic            rd_valid_o,
    input logic            rd_ready_i,
    input logic [DW_W-1:0] rd_data_o
);
    logic [CNT_W:0] n_acc;
    logic           any_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_acc  <= '0;
            any_wr <= 1'b0;
        end else if (start_i || abort_i) begin
            n_acc  <= '0;
            any_wr <= 1'b0;
        end else if (wr_valid_i && wr_ready_o) begin
            n_acc  <= n_acc + (CNT_W+1)'(1);
            any_wr <= 1'b1;
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        n_acc <= (CNT_W+1)'(LINE_QW));

    a_r7_valid_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> any_wr);

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && !start_i && !abort_i) |=> (rd_valid_o && $stable(rd_data_o)));

    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!rd_valid_o && !wr_ready_o));

    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i) |=> (wr_ready_o && !rd_valid_o));
endmodule

bind lrb_line_buf lrb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_data_o  (rd_data_o)
);

// File: tb/lrb_line_buf_tb.sv
module lrb_line_buf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  start_addr_i = '0;
    logic        abort_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic        wr_src_i = 1'b0;
    logic [63:0] wr_data_i = '0;
    logic        wr_ready_o;
    logic        rd_valid_o;
    logic        rd_ready_i = 1'b0;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrb_line_buf u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .abort_i(abort_i), .wr_valid_i(wr_valid_i), .wr_src_i(wr_src_i),
        .wr_data_i(wr_data_i), .wr_ready_o(wr_ready_o), .rd_valid_o(rd_valid_o),
        .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o)
    );

    function automatic logic [31:0] lo(int k); return 32'hA000_0000 + 32'(k); endfunction
    function automatic logic [31:0] hi(int k); return 32'hB000_0000 + 32'(k); endfunction
    function automatic logic [63:0] qd(int k); return {hi(k), lo(k)}; endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All operations begin just after a falling edge and end at the next one.
    task automatic op_start(logic [2:0] addr);
        start_i = 1'b1; start_addr_i = addr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic op_abort();
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
    endtask

    task automatic op_write(logic src, logic [63:0] d, logic exp_rdy, string req);
        wr_valid_i = 1'b1; wr_src_i = src; wr_data_i = d;
        #1 chk(wr_ready_o == exp_rdy, req, 64'(wr_ready_o), 64'(exp_rdy));
        @(negedge clk);
        wr_valid_i = 1'b0;
    endtask

    task automatic op_read(logic [31:0] exp, string req);
        rd_ready_i = 1'b1;
        #1 chk(rd_valid_o && rd_data_o == exp, req, {31'(0), rd_valid_o, rd_data_o}, {32'd1, exp});
        @(negedge clk);
        rd_ready_i = 1'b0;
    endtask

    task automatic expect_outs(logic exp_wr, logic exp_rd, string req);
        #1 chk(wr_ready_o == exp_wr && rd_valid_o == exp_rd, req,
               {wr_ready_o, rd_valid_o}, {exp_wr, exp_rd});
    endtask

    task automatic t_reset();
        #1 expect_outs(1'b0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_outs(1'b0, 1'b0, "R1 after reset");
    endtask

    task automatic t_even_mem();
        op_start(3'b000);
        expect_outs(1'b1, 1'b0, "R2 start opens");
        for (int k = 0; k < 4; k++) op_write(1'b0, qd(k), 1'b1, "R4 mem write accepted");
        expect_outs(1'b0, 1'b1, "R8 full line refuses");
        for (int k = 0; k < 4; k++) begin
            op_read(lo(k), "R4 low half first");
            op_read(hi(k), "R4 high half second");
        end
        expect_outs(1'b0, 1'b0, "R9 end after drain");
    endtask

    task automatic t_odd_mem();
        op_start(3'b001);
        for (int k = 0; k < 4; k++) op_write(1'b0, qd(k), 1'b1, "R5 mem write accepted");
        op_read(hi(0), "R5 odd first dword");
        for (int k = 1; k < 4; k++) begin
            op_read(lo(k), "R5 continue low");
            op_read(hi(k), "R5 continue high");
        end
        expect_outs(1'b0, 1'b0, "R9 end after odd drain");
    endtask

    task automatic t_stall_abort();
        op_start(3'b000);
        op_write(1'b0, qd(0), 1'b1, "R4 write q0");
        op_read(lo(0), "R7 read q0 low");
        op_read(hi(0), "R7 read q0 high");
        expect_outs(1'b1, 1'b0, "R7 stall without data");
        op_write(1'b0, qd(1), 1'b1, "R4 write q1");
        #1 chk(rd_valid_o && rd_data_o == lo(1), "R7 held while not ready",
               {31'(0), rd_valid_o, rd_data_o}, {32'd1, lo(1)});
        @(negedge clk);
        op_read(lo(1), "R7 resume after write");
        op_abort();
        expect_outs(1'b0, 1'b0, "R10 abort clears");
        op_start(3'b000);
        expect_outs(1'b1, 1'b0, "R10 stale data hidden");
        op_write(1'b0, qd(5), 1'b1, "R10 write after abort");
        op_read(lo(5), "R10 pointers restart at 0");
        op_abort();
    endtask

    task automatic t_wb_drop();
        op_start(3'b100);
        op_write(1'b1, qd(0), 1'b1, "R6 wb arrival 0 accepted");
        expect_outs(1'b1, 1'b0, "R6 arrival 0 dropped");
        op_write(1'b1, qd(1), 1'b1, "R6 wb arrival 1 accepted");
        expect_outs(1'b1, 1'b0, "R6 arrival 1 dropped");
        op_write(1'b1, qd(2), 1'b1, "R6 wb arrival 2 accepted");
        op_write(1'b1, qd(3), 1'b1, "R6 wb arrival 3 accepted");
        expect_outs(1'b0, 1'b1, "R8 two locations fill line end");
        op_read(lo(2), "R6 arrival 2 in loc 0 low");
        op_read(hi(2), "R6 arrival 2 in loc 0 high");
        op_read(lo(3), "R6 arrival 3 low");
        op_read(hi(3), "R6 arrival 3 high");
        expect_outs(1'b0, 1'b0, "R9 end at line boundary");
    endtask

    task automatic t_wb_last_odd();
        op_start(3'b111);
        for (int k = 0; k < 3; k++) op_write(1'b1, qd(k), 1'b1, "R6 early wb accepted");
        expect_outs(1'b1, 1'b0, "R6 early wb dropped");
        op_write(1'b1, qd(3), 1'b1, "R6 last wb accepted");
        expect_outs(1'b0, 1'b1, "R8 one location limit");
        op_read(hi(3), "R3 odd dword of qword 3");
        expect_outs(1'b0, 1'b0, "R9 single dword transaction ends");
    endtask

    task automatic t_mem_offset();
        op_start(3'b010);
        for (int k = 0; k < 3; k++) op_write(1'b0, qd(k + 8), 1'b1, "R4 mem write from loc 0");
        op_write(1'b0, qd(15), 1'b0, "R8 fourth write refused");
        for (int k = 0; k < 3; k++) begin
            op_read(lo(k + 8), "R3 index 1 mem low");
            op_read(hi(k + 8), "R3 index 1 mem high");
        end
        expect_outs(1'b0, 1'b0, "R8 refused write not stored");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_even_mem();
        t_odd_mem();
        t_stall_abort();
        t_wb_drop();
        t_wb_last_odd();
        t_mem_offset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule